// File: doc/BRIEF.md
# Multi-Item Stream Protocol Monitor

This block is a passive observer for a streaming bus whose word is split into `ITEMS` equal slots of `ITEM_W` bits, each slot qualified by its own bit in a valid mask. A source-side ready line and a sink-side ready line form the handshake. A word moves only in a cycle where both are high. The monitor never drives the bus. It watches the word, the mask and both ready lines. It counts accepted words and the valid items they carried, and it latches protocol violations into sticky flags.

Three violations are detected. The first is the source offering a word with an all-zero mask. The second is the offered mask, or the content of a valid slot, changing while the sink stalls. The third is the source dropping its ready line while a stalled word is still waiting. A 2-bit code keeps the kind of the earliest violation since the last clear. A synchronous clear input empties the flags and the code and leaves the counters alone. An active-low synchronous reset returns everything to zero.

Top module: `item_bus_monitor`

## Requirements
- R1: A word counts as accepted only in a cycle where `tx_ready` and `rx_ready` are both high. In any other cycle `word_count` and `item_count` hold their values.
- R2: Each accepted word adds one to `word_count` at the following clock edge. The counter is `CNT_W` bits wide (32 by default) and wraps modulo 2^CNT_W.
- R3: Each accepted word adds the number of set bits of `item_valid` to `item_count`, which also wraps modulo 2^CNT_W. An accepted word with an all-zero mask adds zero items but still counts as one word.
- R4: A cycle with `tx_ready` high and `item_valid` all zero sets `err_empty_mask` at the next edge.
- R5: A stall is a cycle with `tx_ready` high and `rx_ready` low. In the cycle after a stall, if `tx_ready` is high and either `item_valid` differs from the stalled value or any slot k whose stalled mask bit was 1 (bits [k*ITEM_W +: ITEM_W] of `word_data`, slot 0 at the LSB end) differs, then `err_stall_change` is set at the next edge. Changes in slots whose mask bit was 0 are ignored.
- R6: In the cycle after a stall, `tx_ready` low sets `err_early_drop` at the next edge.
- R7: The flags are sticky. They clear only when `err_clear` is high at an edge, and the clear wins over a violation seen in the same cycle. `err_clear` does not change either counter.
- R8: `err_first` is 0 while no flag is set. At the first violation after a reset or clear it records 1 = empty mask, 2 = stall change, 3 = early drop. When several violations occur in that same cycle, the lowest code wins. Later violations do not change it until a clear.
- R9: `rst_n` low at a clock edge clears both counters, all three flags and `err_first`.
- R10: Legal traffic raises no flag. This covers back-to-back accepted words, source idle cycles with arbitrary data and mask, stalls that end in acceptance with the word held, and the sink dropping `rx_ready` while the source is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_clear | input | 1 | Synchronous clear of flags and first-error code |
| word_data | input | ITEMS*ITEM_W | Observed word, slot 0 in the low bits |
| item_valid | input | ITEMS | Observed per-slot valid mask |
| tx_ready | input | 1 | Observed source ready |
| rx_ready | input | 1 | Observed sink ready |
| word_count | output | CNT_W | Accepted words, wrapping |
| item_count | output | CNT_W | Accepted valid items, wrapping |
| err_empty_mask | output | 1 | Sticky: source ready with empty mask |
| err_stall_change | output | 1 | Sticky: word changed during a stall |
| err_early_drop | output | 1 | Sticky: source withdrew a stalled word |
| err_first | output | 2 | Code of the earliest violation since clear |

## Verification
The counting path is exercised with a stream that mixes single-slot, sparse, full and three-of-four masks. These are interleaved with source idles and sink stalls, so that a design counting beats instead of items, or counting during stalls or idles, lands on a wrong total. The stall checks are tried with a held word, with changes confined to invalid slots (which must pass), with a mask change and with a change in a valid slot. Telling these apart shows that the data compare honours the stalled mask. Each violation kind is then injected alone, after another kind, and together with a second kind in one cycle. This separates first-error recording from same-cycle priority, and it separates the clear from a violation arriving with it. A narrow-counter instance run past its range shows wrap behaviour.

// File: rtl/imb_pkg.sv
package imb_pkg;

   typedef enum logic [1:0] {
      VIOL_NONE     = 2'd0,
      VIOL_EMPTY    = 2'd1,
      VIOL_UNSTABLE = 2'd2,
      VIOL_WITHDRAW = 2'd3
   } viol_code_e;

   typedef struct packed {
      logic empty;
      logic unstable;
      logic withdraw;
   } viol_t;

endpackage

// File: rtl/imb_stall_tracker.sv
module imb_stall_tracker
   import imb_pkg::*;
#(
   parameter int ITEMS      = 4,
   parameter int ITEM_W     = 8,
   parameter bit CHECK_DATA = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ITEMS*ITEM_W-1:0] word_data,
   input  logic [ITEMS-1:0]        item_valid,
   input  logic                    tx_ready,
   input  logic                    rx_ready,
   output viol_t                   viol
);

   localparam int WORD_W = ITEMS * ITEM_W;

   logic              stalled_q;
   logic [ITEMS-1:0]  mask_q;
   logic [WORD_W-1:0] word_q;
   logic [ITEMS-1:0]  slot_diff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stalled_q <= 1'b0;
      end else begin
         stalled_q <= tx_ready & ~rx_ready;
      end
      mask_q <= item_valid;
      word_q <= word_data;
   end

   for (genvar k = 0; k < ITEMS; k++) begin : g_slot
      if (CHECK_DATA) begin : g_cmp
         assign slot_diff[k] = mask_q[k] &&
            (word_data[k*ITEM_W +: ITEM_W] != word_q[k*ITEM_W +: ITEM_W]);
      end else begin : g_skip
         assign slot_diff[k] = 1'b0;
      end
   end

   always_comb begin
      viol.empty    = tx_ready && (item_valid == '0);
      viol.unstable = stalled_q && tx_ready &&
                      ((item_valid != mask_q) || (|slot_diff));
      viol.withdraw = stalled_q && !tx_ready;
   end

endmodule

// File: rtl/imb_err_log.sv
module imb_err_log
   import imb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       err_clear,
   input  viol_t      viol,
   output viol_t      flags,
   output logic [1:0] first_code
);

   viol_code_e code_q;
   viol_code_e code_now;

   always_comb begin
      if (viol.empty)         code_now = VIOL_EMPTY;
      else if (viol.unstable) code_now = VIOL_UNSTABLE;
      else if (viol.withdraw) code_now = VIOL_WITHDRAW;
      else                    code_now = VIOL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || err_clear) begin
         flags  <= '0;
         code_q <= VIOL_NONE;
      end else begin
         flags <= flags | viol;
         if (code_q == VIOL_NONE) begin
            code_q <= code_now;
         end
      end
   end

   assign first_code = code_q;

endmodule

// File: rtl/imb_counters.sv
module imb_counters #(
   parameter int ITEMS = 4,
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [ITEMS-1:0] item_valid,
   output logic [CNT_W-1:0] word_count,
   output logic [CNT_W-1:0] item_count
);

   localparam int PC_W = $clog2(ITEMS + 1);

   logic [PC_W-1:0] pop;

   if (ITEMS == 1) begin : g_pop_single
      assign pop = item_valid;
   end else begin : g_pop_loop
      always_comb begin
         pop = '0;
         for (int k = 0; k < ITEMS; k++) begin
            pop = pop + PC_W'(item_valid[k]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_count <= '0;
         item_count <= '0;
      end else if (accept) begin
         word_count <= word_count + CNT_W'(1);
         item_count <= item_count + CNT_W'(pop);
      end
   end

endmodule

// File: rtl/item_bus_monitor.sv
module item_bus_monitor
   import imb_pkg::*;
#(
   parameter int ITEMS      = 4,
   parameter int ITEM_W     = 8,
   parameter int CNT_W      = 32,
   parameter bit CHECK_DATA = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    err_clear,
   input  logic [ITEMS*ITEM_W-1:0] word_data,
   input  logic [ITEMS-1:0]        item_valid,
   input  logic                    tx_ready,
   input  logic                    rx_ready,
   output logic [CNT_W-1:0]        word_count,
   output logic [CNT_W-1:0]        item_count,
   output logic                    err_empty_mask,
   output logic                    err_stall_change,
   output logic                    err_early_drop,
   output logic [1:0]              err_first
);

   localparam int PC_W = $clog2(ITEMS + 1);

   if (ITEMS < 1) begin : g_bad_items
      $error("item_bus_monitor: ITEMS must be at least 1");
   end
   if (ITEM_W < 1) begin : g_bad_width
      $error("item_bus_monitor: ITEM_W must be at least 1");
   end
   if (CNT_W < PC_W) begin : g_bad_cnt
      $error("item_bus_monitor: CNT_W too narrow for one word of items");
   end

   viol_t viol;
   viol_t flags;
   logic  accept;

   assign accept = tx_ready & rx_ready;

   imb_stall_tracker #(
      .ITEMS      (ITEMS),
      .ITEM_W     (ITEM_W),
      .CHECK_DATA (CHECK_DATA)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_data  (word_data),
      .item_valid (item_valid),
      .tx_ready   (tx_ready),
      .rx_ready   (rx_ready),
      .viol       (viol)
   );

   imb_err_log u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .err_clear  (err_clear),
      .viol       (viol),
      .flags      (flags),
      .first_code (err_first)
   );

   imb_counters #(
      .ITEMS (ITEMS),
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .item_valid (item_valid),
      .word_count (word_count),
      .item_count (item_count)
   );

   assign err_empty_mask   = flags.empty;
   assign err_stall_change = flags.unstable;
   assign err_early_drop   = flags.withdraw;

endmodule

// File: rtl/imb_monitor_checker.sv
module imb_monitor_checker #(
   parameter int ITEMS = 4,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             err_clear,
   input logic [ITEMS-1:0] item_valid,
   input logic             tx_ready,
   input logic             rx_ready,
   input logic [CNT_W-1:0] word_count,
   input logic [CNT_W-1:0] item_count,
   input logic             err_empty_mask,
   input logic             err_stall_change,
   input logic             err_early_drop,
   input logic [1:0]       err_first
);

   logic [2:0] flg;
   assign flg = {err_empty_mask, err_stall_change, err_early_drop};

   p_word_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_ready && rx_ready) |=> ($stable(word_count) && $stable(item_count)));

   p_word_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && rx_ready) |=> (word_count == CNT_W'($past(word_count) + CNT_W'(1))));

   p_item_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && rx_ready) |=>
         (item_count == CNT_W'($past(item_count) + CNT_W'($countones($past(item_valid))))));

   p_empty_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && (item_valid == '0) && !err_clear) |=> err_empty_mask);

   p_mask_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !rx_ready) ##1 (tx_ready && !err_clear && !$stable(item_valid))
         |=> err_stall_change);

   p_early_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !rx_ready) ##1 (!tx_ready && !err_clear) |=> err_early_drop);

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !err_clear |=> ((flg & $past(flg)) == $past(flg)));

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_clear |=> ((flg == 3'b000) && (err_first == 2'd0)));

   p_code_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((err_first != 2'd0) == (flg != 3'b000)));

   p_code_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_first != 2'd0) && !err_clear) |=> $stable(err_first));

endmodule

bind item_bus_monitor imb_monitor_checker #(
   .ITEMS (ITEMS),
   .CNT_W (CNT_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .err_clear        (err_clear),
   .item_valid       (item_valid),
   .tx_ready         (tx_ready),
   .rx_ready         (rx_ready),
   .word_count       (word_count),
   .item_count       (item_count),
   .err_empty_mask   (err_empty_mask),
   .err_stall_change (err_stall_change),
   .err_early_drop   (err_early_drop),
   .err_first        (err_first)
);

// File: tb/sim_item_bus_monitor.sv
`timescale 1ns/1ps
module sim_item_bus_monitor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        err_clear = 1'b0;
   logic [31:0] word_data = '0;
   logic [3:0]  item_valid = '0;
   logic        tx_ready = 1'b0;
   logic        rx_ready = 1'b0;

   logic [31:0] word_count, item_count;
   logic        e_empty, e_stall, e_drop;
   logic [1:0]  e_first;
   logic [3:0]  n_words, n_items;
   logic        n_empty, n_stall, n_drop;
   logic [1:0]  n_first;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   item_bus_monitor u0 (
      .clk (clk), .rst_n (rst_n), .err_clear (err_clear),
      .word_data (word_data), .item_valid (item_valid),
      .tx_ready (tx_ready), .rx_ready (rx_ready),
      .word_count (word_count), .item_count (item_count),
      .err_empty_mask (e_empty), .err_stall_change (e_stall),
      .err_early_drop (e_drop), .err_first (e_first)
   );

   item_bus_monitor #(.CNT_W(4)) u1 (
      .clk (clk), .rst_n (rst_n), .err_clear (err_clear),
      .word_data (word_data), .item_valid (item_valid),
      .tx_ready (tx_ready), .rx_ready (rx_ready),
      .word_count (n_words), .item_count (n_items),
      .err_empty_mask (n_empty), .err_stall_change (n_stall),
      .err_early_drop (n_drop), .err_first (n_first)
   );

   // {tx, rx, mask[3:0], data[31:0], expected words[7:0], expected items[7:0]}
   localparam int NV = 14;
   localparam logic [53:0] VEC [NV] = '{
      {1'b0, 1'b1, 4'b0000, 32'hDEADBEEF, 8'd0, 8'd0},
      {1'b1, 1'b1, 4'b1110, 32'h11223344, 8'd1, 8'd3},
      {1'b1, 1'b1, 4'b0001, 32'h000000AA, 8'd2, 8'd4},
      {1'b1, 1'b0, 4'b1111, 32'hA1B2C3D4, 8'd2, 8'd4},
      {1'b1, 1'b0, 4'b1111, 32'hA1B2C3D4, 8'd2, 8'd4},
      {1'b1, 1'b1, 4'b1111, 32'hA1B2C3D4, 8'd3, 8'd8},
      {1'b0, 1'b1, 4'b0000, 32'h5A5A5A5A, 8'd3, 8'd8},
      {1'b1, 1'b0, 4'b0101, 32'h00550066, 8'd3, 8'd8},
      {1'b1, 1'b0, 4'b0101, 32'hFF55EE66, 8'd3, 8'd8},
      {1'b1, 1'b1, 4'b0101, 32'hFF55EE66, 8'd4, 8'd10},
      {1'b1, 1'b1, 4'b1000, 32'h77000000, 8'd5, 8'd11},
      {1'b1, 1'b1, 4'b0110, 32'h00BBCC00, 8'd6, 8'd13},
      {1'b0, 1'b0, 4'b1111, 32'h12345678, 8'd6, 8'd13},
      {1'b1, 1'b1, 4'b1011, 32'h99008877, 8'd7, 8'd16}
   };

   task automatic step(input logic tx, input logic rx, input logic [3:0] m,
                       input logic [31:0] d, input logic clr);
      tx_ready   = tx;
      rx_ready   = rx;
      item_valid = m;
      word_data  = d;
      err_clear  = clr;
      @(posedge clk);
      @(negedge clk);
      err_clear  = 1'b0;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_err(input string req, input logic [2:0] f, input logic [1:0] c);
      chk(req, "flags {empty,stall,drop}", {61'd0, e_empty, e_stall, e_drop}, {61'd0, f});
      chk(req, "first code", {62'd0, e_first}, {62'd0, c});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step(1'b0, 1'b0, 4'b0, 32'h0, 1'b0);
      step(1'b0, 1'b0, 4'b0, 32'h0, 1'b0);
      // R9: state after reset
      chk("R9", "word_count", {32'd0, word_count}, 64'd0);
      chk("R9", "item_count", {32'd0, item_count}, 64'd0);
      chk_err("R9", 3'b000, 2'd0);
      rst_n = 1'b1;

      // R1 R2 R3 R5 R10: legal stream walked from the table
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][53], VEC[i][52], VEC[i][51:48], VEC[i][47:16], 1'b0);
         chk("R1/R2", $sformatf("words vec %0d", i), {32'd0, word_count}, {56'd0, VEC[i][15:8]});
         chk("R3", $sformatf("items vec %0d", i), {32'd0, item_count}, {56'd0, VEC[i][7:0]});
         chk_err("R10", 3'b000, 2'd0);
      end

      // R4: empty mask offered and accepted -> one word, zero items
      step(1'b1, 1'b1, 4'b0000, 32'h0, 1'b0);
      chk_err("R4", 3'b100, 2'd1);
      chk("R3", "empty word count", {32'd0, word_count}, 64'd8);
      chk("R3", "empty word items", {32'd0, item_count}, 64'd16);
      step(1'b0, 1'b0, 4'b0000, 32'h0, 1'b0);
      chk_err("R7", 3'b100, 2'd1);

      // R6 after R4: code stays at the first one
      step(1'b1, 1'b0, 4'b0011, 32'h00001234, 1'b0);
      step(1'b0, 1'b0, 4'b0011, 32'h00001234, 1'b0);
      chk_err("R8", 3'b101, 2'd1);

      // R7: clear leaves counters
      step(1'b0, 1'b0, 4'b0000, 32'h0, 1'b1);
      chk_err("R7", 3'b000, 2'd0);
      chk("R7", "words kept", {32'd0, word_count}, 64'd8);
      chk("R7", "items kept", {32'd0, item_count}, 64'd16);

      // R5: mask change during stall
      step(1'b1, 1'b0, 4'b0011, 32'h0000ABCD, 1'b0);
      step(1'b1, 1'b0, 4'b0111, 32'h0000ABCD, 1'b0);
      chk_err("R5", 3'b010, 2'd2);
      step(1'b1, 1'b1, 4'b0111, 32'h0000ABCD, 1'b0);
      chk("R3", "after stall accept", {32'd0, item_count}, 64'd19);
      step(1'b0, 1'b0, 4'b0000, 32'h0, 1'b1);

      // R5: valid slot 0 data change during stall
      step(1'b1, 1'b0, 4'b0001, 32'h00000011, 1'b0);
      step(1'b1, 1'b0, 4'b0001, 32'h00000022, 1'b0);
      chk_err("R5", 3'b010, 2'd2);
      step(1'b1, 1'b1, 4'b0001, 32'h00000022, 1'b0);
      chk("R2", "words", {32'd0, word_count}, 64'd10);
      chk("R3", "items", {32'd0, item_count}, 64'd20);

      // R7: clear wins over a same-cycle empty-mask violation
      step(1'b1, 1'b1, 4'b0000, 32'h0, 1'b1);
      chk_err("R7", 3'b000, 2'd0);
      chk("R2", "words", {32'd0, word_count}, 64'd11);

      // R6 first: code 3
      step(1'b1, 1'b0, 4'b1000, 32'h55000000, 1'b0);
      step(1'b0, 1'b1, 4'b1000, 32'h55000000, 1'b0);
      chk_err("R6", 3'b001, 2'd3);
      step(1'b0, 1'b0, 4'b0000, 32'h0, 1'b1);

      // R8: empty and stall change in one cycle -> code 1, both flags
      step(1'b1, 1'b0, 4'b0001, 32'h00000001, 1'b0);
      step(1'b1, 1'b1, 4'b0000, 32'h00000001, 1'b0);
      chk_err("R8", 3'b110, 2'd1);
      chk("R3", "items", {32'd0, item_count}, 64'd20);
      step(1'b0, 1'b0, 4'b0000, 32'h0, 1'b1);

      // R2 R3: wrap on narrow counters, 10 full words
      for (int j = 0; j < 10; j++) step(1'b1, 1'b1, 4'b1111, 32'hCAFEF00D, 1'b0);
      chk("R2", "words wide", {32'd0, word_count}, 64'd22);
      chk("R3", "items wide", {32'd0, item_count}, 64'd60);
      chk("R2", "words wrapped", {60'd0, n_words}, 64'd6);
      chk("R3", "items wrapped", {60'd0, n_items}, 64'd12);

      // R9: reset mid-run
      step(1'b1, 1'b1, 4'b0000, 32'h0, 1'b0);
      rst_n = 1'b0;
      step(1'b0, 1'b0, 4'b0000, 32'h0, 1'b0);
      chk("R9", "word_count", {32'd0, word_count}, 64'd0);
      chk("R9", "item_count", {32'd0, item_count}, 64'd0);
      chk_err("R9", 3'b000, 2'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule